// File: doc/BRIEF.md
# Page Access Permission and Fault Evaluator

This block decides whether a memory access may use a page whose table entry has already been found. It takes the entry's protection fields, the segment's two key bits, the current privilege state, the kind of access (load, store or instruction fetch) and two per-class authority masks. It then computes the read/write/execute rights granted to the page. The rights come from three sources that are each evaluated independently and then combined with a bitwise AND. The first is the entry's no-execute and guarded bits. The second is a three-bit protection code interpreted under the selected key. The third is the authority masks, which hold two bits for each class key.

When the access is allowed, the block reports whether the entry's reference bit and change bit must be set. It also forms the real address. When the access is denied, it reports a fault status code that says why. A page whose change bit is still clear is granted without write rights on any non-store access. This forces a later store to come back through this path, so that the change bit gets set.

Each evaluation is started by a one-cycle `in_valid` pulse. The results appear on registered outputs in the next cycle, together with `out_valid`. The block performs no memory writes and does no exception routing.

Top module: `pae_eval`

## Requirements
- R1: The key used for the protection code is `seg_key_user` when `priv_user`=1 and `seg_key_sup` otherwise. The protection code is {`pte_pp_hi`, `pte_pp`[1:0]}. Rights are encoded as bit 2 = read, bit 1 = write, bit 0 = execute.
- R2: With key 0, codes 0, 1 and 2 grant read/write/execute, codes 3 and 6 grant read/execute, and codes 4, 5 and 7 grant nothing.
- R3: With key 1, code 2 grants read/write/execute, codes 1 and 3 grant read/execute, and codes 0, 4, 5, 6 and 7 grant nothing.
- R4: When `pte_noexec` or `pte_guard` is set, execute is removed and read and write are left unchanged.
- R5: Class key k uses bits [2*(31-k)+1 : 2*(31-k)] of `data_mask` and of `fetch_mask`. In `data_mask`, the upper bit removes write and the lower bit removes read. In `fetch_mask`, the lower bit removes execute, but only when `fetch_mask_en`=1.
- R6: The granted rights are the AND of the three sources. The access types are encoded as 0 = load, 1 = store, 2 = fetch and 3 = treated as a load. A load needs read, a store needs write and a fetch needs execute. `allow` is 1 exactly when the needed right is granted.
- R7: On a denial, `fault_code` is non-zero and holds the causes. For a fetch, bit 0 is set when no-execute/guard removed execute. Otherwise bit 1 is set when the protection code removed execute. Bit 2 is set when the fetch mask removed execute. For a load or store, bit 1 is set when the protection code lacks the needed right, bit 2 is set when the data mask removes it, and bit 3 is set on a store. On an allow, `fault_code` is 0.
- R8: On an allow, `ref_req` is 1 when `pte_ref` is 0. `chg_req` is 1 for a store when `pte_chg` is 0. For a non-store with `pte_chg` equal to 0, write is cleared in `rights`.
- R9: On an allow, `raddr` is `pte_rpn` with its low `page_shift` bits replaced by the matching bits of `eaddr`.
- R10: All outputs change one cycle after an `in_valid` pulse. `out_valid` is high for exactly that cycle.
- R11: On a denial, `ref_req` and `chg_req` are 0 and `raddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Starts one evaluation |
| acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| priv_user | input | 1 | 1 = problem (user) state |
| seg_key_user | input | 1 | Segment key bit used in user state |
| seg_key_sup | input | 1 | Segment key bit used in supervisor state |
| pte_pp | input | 2 | Low protection code bits |
| pte_pp_hi | input | 1 | High protection code bit |
| pte_noexec | input | 1 | Entry no-execute bit |
| pte_guard | input | 1 | Entry guarded bit |
| pte_class | input | 5 | Entry class key |
| pte_ref | input | 1 | Entry reference bit |
| pte_chg | input | 1 | Entry change bit |
| pte_rpn | input | 48 | Entry real page address |
| page_shift | input | 6 | Page size as log2 of bytes |
| eaddr | input | 48 | Effective address |
| data_mask | input | 64 | Load/store authority mask, 2 bits per class |
| fetch_mask | input | 64 | Fetch authority mask, 2 bits per class |
| fetch_mask_en | input | 1 | Enables the fetch mask |
| out_valid | output | 1 | Result valid |
| allow | output | 1 | Access allowed |
| rights | output | 3 | Granted rights {R,W,X} |
| fault_code | output | 4 | Denial causes |
| ref_req | output | 1 | Request to set the reference bit |
| chg_req | output | 1 | Request to set the change bit |
| raddr | output | 48 | Real address |

## Verification
The hardest situations to reach are the ones where several permission sources deny the same access together. Examples are a fetch blocked at once by the guard bit, the protection code and the fetch mask, or a store refused by both the protection code and the data mask. Only the full set of fault bits shows that each source is judged on its own. To get there, the stimulus sweeps every combination of access type, privilege state, both key bits, all eight protection codes, the no-execute and guard bits, both data-mask bits, the fetch-mask bit with its enable, and the reference and change bits. The class key and the page size rotate across the sweep, so that the mask bits land at many positions and the address merge is tried at several widths.

// File: rtl/pae_pkg.sv
package pae_pkg;
  localparam int RB = 2;
  localparam int WB = 1;
  localparam int XB = 0;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  // rights granted by the 3-bit protection code under one key
  function automatic logic [2:0] code_rights(input logic key, input logic [2:0] code);
    logic [2:0] r;
    r = 3'b000;
    if (!key) begin
      case (code)
        3'd0, 3'd1, 3'd2: r = 3'b111;
        3'd3, 3'd6:       r = 3'b101;
        default:          r = 3'b000;
      endcase
    end else begin
      case (code)
        3'd2:       r = 3'b111;
        3'd1, 3'd3: r = 3'b101;
        default:    r = 3'b000;
      endcase
    end
    return r;
  endfunction

  function automatic logic [2:0] need_of(input logic [1:0] a);
    case (a)
      ACC_STORE: need_of = 3'b010;
      ACC_FETCH: need_of = 3'b001;
      default:   need_of = 3'b100;
    endcase
  endfunction

  // merge real page address with page offset
  function automatic logic [47:0] merge_addr(input logic [47:0] rpn,
                                             input logic [47:0] ea,
                                             input logic [5:0]  sh);
    logic [47:0] m;
    m = (48'd1 << sh) - 48'd1;
    return (rpn & ~m) | (ea & m);
  endfunction
endpackage

// File: rtl/pae_key_prot.sv
module pae_key_prot (
  input  logic       priv_user,
  input  logic       key_user,
  input  logic       key_sup,
  input  logic [1:0] pp_lo,
  input  logic       pp_hi,
  output logic       key_sel,
  output logic [2:0] pp_rights
);
  import pae_pkg::*;
  always_comb begin
    key_sel   = priv_user ? key_user : key_sup;
    pp_rights = code_rights(key_sel, {pp_hi, pp_lo});
  end
endmodule

// File: rtl/pae_class_mask.sv
module pae_class_mask #(
  parameter int NKEYS = 32,
  localparam int KW = $clog2(NKEYS),
  localparam int MW = 2 * NKEYS
) (
  input  logic [KW-1:0] cls,
  input  logic [MW-1:0] data_mask,
  input  logic [MW-1:0] fetch_mask,
  input  logic          fetch_en,
  output logic [2:0]    mask_rights
);
  logic [1:0] dbits;
  logic [1:0] fbits;
  int unsigned pos;
  always_comb begin
    pos   = 2 * (NKEYS - 1 - int'(cls));
    dbits = data_mask[pos +: 2];
    fbits = fetch_mask[pos +: 2];
    mask_rights[2] = ~dbits[0];
    mask_rights[1] = ~dbits[1];
    mask_rights[0] = ~(fetch_en & fbits[0]);
  end
endmodule

// File: rtl/pae_fault_enc.sv
module pae_fault_enc (
  input  logic [1:0] acc,
  input  logic       deny,
  input  logic [2:0] need,
  input  logic [2:0] nxg_rights,
  input  logic [2:0] pp_rights,
  input  logic [2:0] mask_rights,
  output logic [3:0] fault
);
  import pae_pkg::*;
  always_comb begin
    fault = 4'b0000;
    if (deny) begin
      if (acc == ACC_FETCH) begin
        if (!nxg_rights[XB])     fault[0] = 1'b1;
        else if (!pp_rights[XB]) fault[1] = 1'b1;
        fault[2] = ~mask_rights[XB];
      end else begin
        fault[1] = |(need & ~pp_rights);
        fault[2] = |(need & ~mask_rights);
        fault[3] = (acc == ACC_STORE);
      end
    end
  end
endmodule

// File: rtl/pae_eval.sv
module pae_eval #(
  parameter int AW    = 48,
  parameter int NKEYS = 32,
  localparam int KW = $clog2(NKEYS),
  localparam int MW = 2 * NKEYS,
  localparam int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    acc,
  input  logic          priv_user,
  input  logic          seg_key_user,
  input  logic          seg_key_sup,
  input  logic [1:0]    pte_pp,
  input  logic          pte_pp_hi,
  input  logic          pte_noexec,
  input  logic          pte_guard,
  input  logic [KW-1:0] pte_class,
  input  logic          pte_ref,
  input  logic          pte_chg,
  input  logic [AW-1:0] pte_rpn,
  input  logic [SW-1:0] page_shift,
  input  logic [AW-1:0] eaddr,
  input  logic [MW-1:0] data_mask,
  input  logic [MW-1:0] fetch_mask,
  input  logic          fetch_mask_en,
  output logic          out_valid,
  output logic          allow,
  output logic [2:0]    rights,
  output logic [3:0]    fault_code,
  output logic          ref_req,
  output logic          chg_req,
  output logic [AW-1:0] raddr
);
  import pae_pkg::*;

  // named internal events
  logic          key_sel;
  logic [2:0]    pp_rights;
  logic [2:0]    nxg_rights;
  logic [2:0]    mask_rights;
  logic [2:0]    comb_rights;
  logic [2:0]    need;
  logic          allow_c;
  logic [3:0]    fault_c;
  logic          ref_c;
  logic          chg_c;
  logic [2:0]    rights_c;
  logic [AW-1:0] raddr_c;
  logic [AW-1:0] mask_c;

  pae_key_prot u_key (
    .priv_user (priv_user),
    .key_user  (seg_key_user),
    .key_sup   (seg_key_sup),
    .pp_lo     (pte_pp),
    .pp_hi     (pte_pp_hi),
    .key_sel   (key_sel),
    .pp_rights (pp_rights)
  );

  pae_class_mask #(.NKEYS(NKEYS)) u_mask (
    .cls         (pte_class),
    .data_mask   (data_mask),
    .fetch_mask  (fetch_mask),
    .fetch_en    (fetch_mask_en),
    .mask_rights (mask_rights)
  );

  always_comb begin
    nxg_rights  = {2'b11, ~(pte_noexec | pte_guard)};
    comb_rights = nxg_rights & pp_rights & mask_rights;
    need        = need_of(acc);
    allow_c     = (need & ~comb_rights) == 3'b000;
    ref_c       = allow_c & ~pte_ref;
    chg_c       = allow_c & ~pte_chg & (acc == ACC_STORE);
    rights_c    = comb_rights;
    if (!pte_chg && acc != ACC_STORE) rights_c[WB] = 1'b0;
    mask_c      = (AW'(1) << page_shift) - AW'(1);
    raddr_c     = allow_c ? ((pte_rpn & ~mask_c) | (eaddr & mask_c)) : '0;
  end

  pae_fault_enc u_fault (
    .acc         (acc),
    .deny        (~allow_c),
    .need        (need),
    .nxg_rights  (nxg_rights),
    .pp_rights   (pp_rights),
    .mask_rights (mask_rights),
    .fault       (fault_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      allow      <= 1'b0;
      rights     <= 3'b000;
      fault_code <= 4'b0000;
      ref_req    <= 1'b0;
      chg_req    <= 1'b0;
      raddr      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        allow      <= allow_c;
        rights     <= rights_c;
        fault_code <= fault_c;
        ref_req    <= ref_c;
        chg_req    <= chg_c;
        raddr      <= raddr_c;
      end
    end
  end
endmodule

// File: rtl/pae_eval_chk.sv
module pae_eval_chk #(
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    acc,
  input logic          pte_noexec,
  input logic          pte_guard,
  input logic          out_valid,
  input logic          allow,
  input logic [2:0]    rights,
  input logic [3:0]    fault_code,
  input logic          ref_req,
  input logic          chg_req,
  input logic [AW-1:0] raddr
);
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_deny_has_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !allow) |-> fault_code != 4'b0000);
  assert_allow_no_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && allow) |-> fault_code == 4'b0000);
  assert_deny_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !allow) |-> (!ref_req && !chg_req && raddr == '0));
  assert_chg_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc != 2'd1) |=> !chg_req);
  assert_nxg_no_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (pte_noexec || pte_guard)) |=> !rights[0]);
endmodule

bind pae_eval pae_eval_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .acc        (acc),
  .pte_noexec (pte_noexec),
  .pte_guard  (pte_guard),
  .out_valid  (out_valid),
  .allow      (allow),
  .rights     (rights),
  .fault_code (fault_code),
  .ref_req    (ref_req),
  .chg_req    (chg_req),
  .raddr      (raddr)
);

// File: tb/sim_pae_eval.sv
module sim_pae_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  acc = '0;
  logic        priv_user = 1'b0, seg_key_user = 1'b0, seg_key_sup = 1'b0;
  logic [1:0]  pte_pp = '0;
  logic        pte_pp_hi = 1'b0, pte_noexec = 1'b0, pte_guard = 1'b0;
  logic [4:0]  pte_class = '0;
  logic        pte_ref = 1'b0, pte_chg = 1'b0;
  logic [47:0] pte_rpn = '0, eaddr = '0;
  logic [5:0]  page_shift = 6'd12;
  logic [63:0] data_mask = '0, fetch_mask = '0;
  logic        fetch_mask_en = 1'b0;
  logic        out_valid, allow, ref_req, chg_req;
  logic [2:0]  rights;
  logic [3:0]  fault_code;
  logic [47:0] raddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pae_eval u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc(acc),
    .priv_user(priv_user), .seg_key_user(seg_key_user), .seg_key_sup(seg_key_sup),
    .pte_pp(pte_pp), .pte_pp_hi(pte_pp_hi), .pte_noexec(pte_noexec),
    .pte_guard(pte_guard), .pte_class(pte_class), .pte_ref(pte_ref),
    .pte_chg(pte_chg), .pte_rpn(pte_rpn), .page_shift(page_shift),
    .eaddr(eaddr), .data_mask(data_mask), .fetch_mask(fetch_mask),
    .fetch_mask_en(fetch_mask_en), .out_valid(out_valid), .allow(allow),
    .rights(rights), .fault_code(fault_code), .ref_req(ref_req),
    .chg_req(chg_req), .raddr(raddr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent restatement of protection-code table
  function automatic logic [2:0] exp_code(input logic k, input int c);
    logic rd, wr;
    if (k == 1'b0) begin
      rd = (c < 4) || (c == 6);
      wr = (c < 3);
    end else begin
      rd = (c == 1) || (c == 2) || (c == 3);
      wr = (c == 2);
    end
    return {rd, wr, rd};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset allow", {63'd0, allow}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle", {63'd0, out_valid}, 64'd0);
    for (int a = 0; a < 3; a++)
    for (int ps = 0; ps < 2; ps++)
    for (int ku = 0; ku < 2; ku++)
    for (int ks = 0; ks < 2; ks++)
    for (int cd = 0; cd < 8; cd++)
    for (int nx = 0; nx < 2; nx++)
    for (int gd = 0; gd < 2; gd++)
    for (int ab = 0; ab < 4; ab++)
    for (int ib = 0; ib < 2; ib++)
    for (int ie = 0; ie < 2; ie++)
    for (int rc = 0; rc < 4; rc++) begin
      logic k;
      logic [2:0] pr, xr, mr, g, nd, er;
      logic [3:0] ef;
      logic ea_ok, e_ref, e_chg;
      logic [47:0] ra;
      int cls, sh;
      n++;
      cls = (n * 7) % 32;
      sh  = (n % 3 == 0) ? 12 : ((n % 3 == 1) ? 16 : 24);
      acc = 2'(a); priv_user = ps[0]; seg_key_user = ku[0]; seg_key_sup = ks[0];
      pte_pp = cd[1:0]; pte_pp_hi = cd[2]; pte_noexec = nx[0]; pte_guard = gd[0];
      pte_class = 5'(cls); pte_ref = rc[0]; pte_chg = rc[1];
      pte_rpn = {16'h00a5, 32'(n * 32'h9e3779b1)};
      eaddr   = {16'h5a00, 32'(n * 32'h7f4a7c15)};
      page_shift = 6'(sh);
      data_mask  = 64'(ab) << (62 - 2 * cls);
      fetch_mask = 64'(ib) << (62 - 2 * cls);
      fetch_mask_en = ie[0];
      in_valid = 1'b1;
      // R1 key pick, R2/R3 table, R4, R5 masks, R6 AND
      k  = ps ? ku[0] : ks[0];
      pr = exp_code(k, cd);
      xr = (nx || gd) ? 3'b110 : 3'b111;
      mr = {~ab[0], ~ab[1], ~(ib[0] & ie[0])};
      g  = pr & xr & mr;
      nd = (a == 1) ? 3'b010 : ((a == 2) ? 3'b001 : 3'b100);
      ea_ok = (g & nd) != 0;
      er = g;
      if (!rc[1] && a != 1) er[1] = 1'b0;
      ef = 4'd0;
      if (!ea_ok) begin
        if (a == 2) begin
          ef[0] = ~xr[0];
          ef[1] = xr[0] & ~pr[0];
          ef[2] = ~mr[0];
        end else begin
          ef[1] = (pr & nd) == 0;
          ef[2] = (mr & nd) == 0;
          ef[3] = (a == 1);
        end
      end
      e_ref = ea_ok && !rc[0];
      e_chg = ea_ok && !rc[1] && (a == 1);
      ra = 48'd0;
      if (ea_ok)
        for (int b = 0; b < 48; b++) ra[b] = (b < sh) ? eaddr[b] : pte_rpn[b];
      @(negedge clk);
      in_valid = 1'b0;
      check("R10 out_valid", {63'd0, out_valid}, 64'd1);
      check("R6 allow", {63'd0, allow}, {63'd0, ea_ok});
      check("R8 rights R1 R2 R3 R4 R5", {61'd0, rights}, {61'd0, er});
      check("R7 fault_code", {60'd0, fault_code}, {60'd0, ef});
      check("R8 R11 updates", {62'd0, ref_req, chg_req}, {62'd0, e_ref, e_chg});
      check("R9 R11 raddr", {16'd0, raddr}, {16'd0, ra});
      @(negedge clk);
      check("R10 pulse", {63'd0, out_valid}, 64'd0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule